// File: doc/BRIEF.md
# Vectored Maskable Interrupt Controller

This block collects eight event conditions from a two-channel serial controller and turns them into one active-low interrupt request for a host processor. Each condition is a level held high by its source until that source's own service action clears it. The block samples these levels into a status register. A mask register chooses which conditions may drive the request.

The host reaches the block through a small asynchronous-style register port. It uses a chip select, a read/write select, an address, write and read data, and a data-acknowledge strobe that the block drives. When the host runs an interrupt acknowledge cycle while an enabled condition is pending, the block places a programmable vector byte on the read data and acknowledges. When nothing enabled is pending, the block leaves the acknowledge unanswered.

Five general-purpose output pins are also driven. Each pin comes either from a latch the host writes or, when its route bit is set, from a dedicated active-low copy of one source. These control and strobe pins are plain levels. The port carries no streaming data, so no valid/ready flow control applies.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, irq_n and dtack_n are high, rdata_oe is low, the mask (address 0), route (address 3) and latch (address 4) registers read 0, gp_out is 0, and the vector register (address 2) reads 0x0F.
- R2: Status (address 1, read only) equals the evt levels sampled at the previous clock edge, for every bit, whatever the mask holds.
- R3: irq_n is low exactly when some status bit and the matching mask bit are both 1. A change on evt reaches irq_n one clock edge later. irq_n stays high while every pending event is masked.
- R4: The mask register at address 0 is written and read back whole. Reading status does not clear any status bit or release irq_n.
- R5: After chip select is sampled low on an edge, dtack_n is low from that edge on. dtack_n returns high on the first edge that samples chip select high. During a read, rdata_oe is high and rdata holds the addressed register while dtack_n is low.
- R6: Writes to address 1 (status) and to unused addresses 5 to 7 change no register.
- R7: An edge that samples iack_n low while an enabled condition is pending starts an acknowledge. From that edge on, rdata carries the vector register, rdata_oe is high and dtack_n is low. Both are released on the first edge that samples iack_n high.
- R8: When iack_n is sampled low with no enabled condition pending, dtack_n stays high and rdata_oe stays low for as long as iack_n is held low. This holds even if masked conditions are pending.
- R9: The vector register at address 2 is written and read back whole.
- R10: Each gp_out[i] follows latch bit i while route bit i (address 3, bits 0 to 4) is 0. While route bit i is 1, gp_out[i] is low exactly when its source status bit is 1. The pin-to-source map is i=0 to status bit 3, i=1 to bit 1, i=2 to bit 5, i=3 to bit 0, and i=4 to bit 4.
- R11: A register write takes effect once per access. The block uses the wdata present on the first edge that samples chip select low and ignores later changes while chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Register access select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| evt | input | 8 | Event condition levels |
| rdata | output | 8 | Read data / vector |
| rdata_oe | output | 1 | Read data is being driven |
| dtack_n | output | 1 | Data acknowledge, active low |
| irq_n | output | 1 | Interrupt request, active low |
| gp_out | output | 5 | General outputs 3 to 7 |

## Verification
Status, irq_n and routed gp_out pins follow evt one edge after evt changes. The bench drives evt on a falling edge. It checks irq_n just before the next rising edge, where the old value must remain, and again on the following falling edge, where the new value is due. dtack_n, rdata_oe and rdata respond on the first rising edge that samples a strobe low and release on the first rising edge that samples it high. Each bus task therefore samples on the falling edge after each of those rising edges. Results are pushed to a scoreboard queue with their expected values and compared in order by a separate monitor.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int A_MASK  = 0;
  localparam int A_STAT  = 1;
  localparam int A_VEC   = 2;
  localparam int A_ROUTE = 3;
  localparam int A_LATCH = 4;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_REG  = 2'd1,
    BUS_ACK  = 2'd2,
    BUS_SKIP = 2'd3
  } bus_state_e;

  // status bit that drives each discrete output pin
  function automatic int pin_src(input int pin);
    case (pin)
      0: pin_src = 3;
      1: pin_src = 1;
      2: pin_src = 5;
      3: pin_src = 0;
      default: pin_src = 4;
    endcase
  endfunction
endpackage

// File: rtl/vic_regs.sv
module vic_regs #(
  parameter int NSRC    = 8,
  parameter int DW      = 8,
  parameter int AW      = 3,
  parameter int NPIN    = 5,
  parameter logic [DW-1:0] VEC_RST = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            wr_stb,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rd_mux,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] mask_q,
  output logic [DW-1:0]   vector_q,
  output logic [NPIN-1:0] route_q,
  output logic [NPIN-1:0] latch_q
);
  import vic_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      vector_q <= VEC_RST;
      route_q  <= '0;
      latch_q  <= '0;
    end else begin
      status_q <= evt;
      if (wr_stb) begin
        case (int'(addr))
          A_MASK:  mask_q   <= wdata[NSRC-1:0];
          A_VEC:   vector_q <= wdata;
          A_ROUTE: route_q  <= wdata[NPIN-1:0];
          A_LATCH: latch_q  <= wdata[NPIN-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (int'(addr))
      A_MASK:  rd_mux = DW'(mask_q);
      A_STAT:  rd_mux = DW'(status_q);
      A_VEC:   rd_mux = vector_q;
      A_ROUTE: rd_mux = DW'(route_q);
      A_LATCH: rd_mux = DW'(latch_q);
      default: rd_mux = '0;
    endcase
  end

  // R4
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && int'(addr) == A_MASK) |=> (mask_q == $past(wdata[NSRC-1:0])));

  // R6
  stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && int'(addr) == A_STAT) |=>
      (mask_q == $past(mask_q) && vector_q == $past(vector_q) &&
       route_q == $past(route_q) && latch_q == $past(latch_q)));
endmodule

// File: rtl/vic_bus.sv
module vic_bus #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rw,
  input  logic          iack_n,
  input  logic          pend,
  input  logic [DW-1:0] rd_mux,
  input  logic [DW-1:0] vector_q,
  output logic          wr_stb,
  output logic          dtack_n,
  output logic          rdata_oe,
  output logic [DW-1:0] rdata
);
  import vic_pkg::*;

  bus_state_e    st_q;
  logic          dtack_q;
  logic          oe_q;
  logic [DW-1:0] rdata_q;

  // one write pulse, only on the edge that opens a register access
  assign wr_stb = (st_q == BUS_IDLE) && iack_n && !cs_n && !rw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= BUS_IDLE;
      dtack_q <= 1'b0;
      oe_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        BUS_IDLE: begin
          if (!iack_n) begin
            if (pend) begin
              rdata_q <= vector_q;
              oe_q    <= 1'b1;
              dtack_q <= 1'b1;
              st_q    <= BUS_ACK;
            end else begin
              st_q    <= BUS_SKIP;
            end
          end else if (!cs_n) begin
            dtack_q <= 1'b1;
            oe_q    <= rw;
            if (rw) rdata_q <= rd_mux;
            st_q    <= BUS_REG;
          end
        end
        BUS_REG: if (cs_n) begin
          dtack_q <= 1'b0;
          oe_q    <= 1'b0;
          st_q    <= BUS_IDLE;
        end
        BUS_ACK: if (iack_n) begin
          dtack_q <= 1'b0;
          oe_q    <= 1'b0;
          st_q    <= BUS_IDLE;
        end
        default: if (iack_n) st_q <= BUS_IDLE;
      endcase
    end
  end

  assign dtack_n  = ~dtack_q;
  assign rdata_oe = oe_q;
  assign rdata    = rdata_q;

  // R5
  dtack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> ($past(!cs_n) || $past(!iack_n)));

  // R5
  dtack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && iack_n) |=> dtack_n);

  // R8
  no_pend_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BUS_IDLE && !iack_n && !pend) |=> (dtack_n && !rdata_oe));

  // R7
  oe_with_dtack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> !dtack_n);
endmodule

// File: rtl/vic_outsel.sv
module vic_outsel #(
  parameter int NSRC = 8,
  parameter int NPIN = 5
) (
  input  logic [NSRC-1:0] status_q,
  input  logic [NPIN-1:0] route_q,
  input  logic [NPIN-1:0] latch_q,
  output logic [NPIN-1:0] gp_out
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam int SRC = vic_pkg::pin_src(i);
    assign gp_out[i] = route_q[i] ? ~status_q[SRC] : latch_q[i];
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC = 8,
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter int NPIN = 5,
  parameter logic [DW-1:0] VEC_RST = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            rw,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            iack_n,
  input  logic [NSRC-1:0] evt,
  output logic [DW-1:0]   rdata,
  output logic            rdata_oe,
  output logic            dtack_n,
  output logic            irq_n,
  output logic [NPIN-1:0] gp_out
);
  logic            wr_stb;
  logic [DW-1:0]   rd_mux;
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] mask_q;
  logic [DW-1:0]   vector_q;
  logic [NPIN-1:0] route_q;
  logic [NPIN-1:0] latch_q;
  logic            pend;

  vic_regs #(.NSRC(NSRC), .DW(DW), .AW(AW), .NPIN(NPIN), .VEC_RST(VEC_RST)) regs_i (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr_stb(wr_stb), .addr(addr),
    .wdata(wdata), .rd_mux(rd_mux), .status_q(status_q), .mask_q(mask_q),
    .vector_q(vector_q), .route_q(route_q), .latch_q(latch_q)
  );

  assign pend  = |(status_q & mask_q);
  assign irq_n = ~pend;

  vic_bus #(.DW(DW)) bus_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .iack_n(iack_n),
    .pend(pend), .rd_mux(rd_mux), .vector_q(vector_q), .wr_stb(wr_stb),
    .dtack_n(dtack_n), .rdata_oe(rdata_oe), .rdata(rdata)
  );

  vic_outsel #(.NSRC(NSRC), .NPIN(NPIN)) outsel_i (
    .status_q(status_q), .route_q(route_q), .latch_q(latch_q), .gp_out(gp_out)
  );

  // R3
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> ($past(|evt) || $past(!irq_n)));
endmodule

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       rw = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       iack_n = 1'b1;
  logic [7:0] evt = '0;
  logic [7:0] rdata;
  logic       rdata_oe, dtack_n, irq_n;
  logic [4:0] gp_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  string       rid_q[$];
  logic [15:0] exp_q[$];
  logic [15:0] act_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr), .wdata(wdata),
    .iack_n(iack_n), .evt(evt), .rdata(rdata), .rdata_oe(rdata_oe),
    .dtack_n(dtack_n), .irq_n(irq_n), .gp_out(gp_out)
  );

  // driver side: push observed and expected items
  task automatic chk(input string rid, input logic [15:0] act, input logic [15:0] exp);
    rid_q.push_back(rid);
    act_q.push_back(act);
    exp_q.push_back(exp);
  endtask

  // monitor: pops and compares in order
  task automatic drain();
    while (act_q.size() > 0) begin
      automatic string       r = rid_q.pop_front();
      automatic logic [15:0] a = act_q.pop_front();
      automatic logic [15:0] e = exp_q.pop_front();
      n_checks++;
      if (a !== e) begin
        n_errors++;
        $display("FAIL %s actual=%h expected=%h", r, a, e);
      end
    end
  endtask

  always @(negedge clk) drain();

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d, input bit tchk);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    if (tchk) chk("R5 write dtack low", {15'd0, dtack_n}, 16'd0);
    cs_n = 1'b1;
    @(negedge clk);
    if (tchk) chk("R5 write dtack released", {15'd0, dtack_n}, 16'd1);
  endtask

  task automatic reg_rd(input string rid, input logic [2:0] a, input logic [7:0] e);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; addr = a;
    @(negedge clk);
    chk(rid, {6'd0, rdata_oe, dtack_n, rdata}, {6'd0, 1'b1, 1'b0, e});
    cs_n = 1'b1;
    @(negedge clk);
    chk("R5 read release", {14'd0, rdata_oe, dtack_n}, 16'd1);
  endtask

  task automatic set_evt(input logic [7:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 irq_n", {15'd0, irq_n}, 16'd1);
    chk("R1 dtack_n/oe", {14'd0, dtack_n, rdata_oe}, 16'd2);
    chk("R1 gp_out", {11'd0, gp_out}, 16'd0);
    reg_rd("R1 mask", 3'd0, 8'h00);
    reg_rd("R1 vector", 3'd2, 8'h0F);
    reg_rd("R1 route", 3'd3, 8'h00);
    reg_rd("R1 latch", 3'd4, 8'h00);

    // R2: status follows evt with mask clear; R3 masked keeps irq high
    set_evt(8'hA5);
    reg_rd("R2 status A5", 3'd1, 8'hA5);
    chk("R3 masked no irq", {15'd0, irq_n}, 16'd1);
    set_evt(8'h00);
    reg_rd("R2 status 00", 3'd1, 8'h00);

    // R4 mask write/read, R3 timing
    reg_wr(3'd0, 8'h02, 1'b1);
    reg_rd("R4 mask readback", 3'd0, 8'h02);
    @(negedge clk);
    evt = 8'h02;
    #1 chk("R3 irq before edge", {15'd0, irq_n}, 16'd1);
    @(negedge clk);
    chk("R3 irq one edge later", {15'd0, irq_n}, 16'd0);
    reg_rd("R4 status read 1", 3'd1, 8'h02);
    reg_rd("R4 status read 2", 3'd1, 8'h02);
    chk("R4 irq after status read", {15'd0, irq_n}, 16'd0);

    // R6 ignored writes
    reg_wr(3'd1, 8'hFF, 1'b0);
    reg_wr(3'd7, 8'hFF, 1'b0);
    reg_wr(3'd5, 8'hFF, 1'b0);
    reg_rd("R6 mask kept", 3'd0, 8'h02);
    reg_rd("R6 vector kept", 3'd2, 8'h0F);
    reg_rd("R6 status kept", 3'd1, 8'h02);
    reg_rd("R6 route kept", 3'd3, 8'h00);
    reg_rd("R6 latch kept", 3'd4, 8'h00);

    // R9 vector
    reg_wr(3'd2, 8'h5A, 1'b0);
    reg_rd("R9 vector readback", 3'd2, 8'h5A);

    // R7 acknowledge with pending
    @(negedge clk);
    iack_n = 1'b0;
    @(negedge clk);
    chk("R7 ack vector", {6'd0, rdata_oe, dtack_n, rdata}, {6'd0, 1'b1, 1'b0, 8'h5A});
    @(negedge clk);
    chk("R7 ack held", {14'd0, rdata_oe, dtack_n}, 16'd2);
    iack_n = 1'b1;
    @(negedge clk);
    chk("R7 ack released", {14'd0, rdata_oe, dtack_n}, 16'd1);

    // R3 clear by source
    @(negedge clk);
    evt = 8'h00;
    @(negedge clk);
    chk("R3 irq released", {15'd0, irq_n}, 16'd1);

    // R8 acknowledge with nothing pending, then with only masked pending
    for (int pass = 0; pass < 2; pass++) begin
      @(negedge clk);
      evt = (pass == 0) ? 8'h00 : 8'h01;
      @(negedge clk);
      iack_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk("R8 no ack", {14'd0, rdata_oe, dtack_n}, 16'd1);
      end
      iack_n = 1'b1;
      @(negedge clk);
    end
    set_evt(8'h00);

    // R10 output pins
    reg_wr(3'd4, 8'h14, 1'b0);
    @(negedge clk);
    chk("R10 latch only", {11'd0, gp_out}, 16'h0014);
    reg_wr(3'd3, 8'h1F, 1'b0);
    set_evt(8'h08);
    chk("R10 ct pin0", {11'd0, gp_out}, 16'h001E);
    set_evt(8'h20);
    chk("R10 rxb pin2", {11'd0, gp_out}, 16'h001B);
    set_evt(8'h13);
    chk("R10 txa rxa txb", {11'd0, gp_out}, 16'h0005);
    reg_wr(3'd3, 8'h01, 1'b0);
    set_evt(8'h20);
    chk("R10 partial route", {11'd0, gp_out}, 16'h0015);
    set_evt(8'h00);

    // R11 one write per access
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b0; addr = 3'd0; wdata = 8'h81;
    @(negedge clk);
    wdata = 8'h7E;
    @(negedge clk);
    wdata = 8'h3C;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    reg_rd("R11 first data kept", 3'd0, 8'h81);

    repeat (3) @(negedge clk);
    drain();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      drain();
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule